// File: doc/BRIEF.md
# Interleaved Reed-Solomon Frame Decoder

This block takes a 120-bit protected link frame on a valid strobe and returns the corrected payload one clock later. The frame carries two Reed-Solomon codewords over GF(16), each with 11 data and 4 check symbols of 4 bits. The two codewords are interleaved symbol by symbol. Each lane can repair up to two bad symbols, so the frame as a whole survives any symbol-aligned 16-bit burst. All syndrome, locator, root-search and error-value logic sits in one combinational cone. The only registers are at the output.

After correction the block splits the 88 data bits into a 4-bit header, a 4-bit control field, a 16-bit timing/trigger field and a 64-bit acquisition field. For each lane it reports whether a repair was made or whether the lane could not be decoded. Two saturating counters give the number of repaired frames and the number of failed frames.

Top module: `rsd_frame_decoder`

## Requirements
- R1: Frame symbol k is `in_frame[4k+3:4k]`. It belongs to lane k mod 2 at codeword position k div 2, and position j is the coefficient of x^j. The field is GF(16) with x^4+x+1, and α is 4'b0010. A valid codeword is zero at α^1, α^2, α^3 and α^4. Positions 4..14 hold data, so the data sits in frame bits [119:32] and the check symbols sit in bits [31:0].
- R2: After correction, `out_hdr` is frame bits [119:116], `out_sc` is [115:112], `out_ttc` is [111:96] and `out_daq` is [95:32].
- R3: A frame whose lanes are both valid codewords is passed through unchanged, with `out_fixed` and `out_fail` both zero.
- R4: If a lane holds one or two wrong symbols, at data or check positions, the lane is restored. Its bit in `out_fixed` (bit 0 for lane 0) is then 1 and its bit in `out_fail` is 0.
- R5: Two wrong symbols in each lane at once are all corrected. This includes any symbol-aligned 16-bit burst anywhere in the frame.
- R6: If a lane cannot be decoded, its `out_fail` bit is set, its `out_fixed` bit is clear and its data symbols are output as received. A flag bit is never 1 in both vectors. `out_bad` is the OR of `out_fail`.
- R7: `out_vld` is 1 in exactly the cycle after each cycle with `in_vld`. Without `in_vld`, the data outputs and flags hold their values and `in_frame` is ignored.
- R8: `cnt_fixed` counts frames with at least one repaired lane and no failed lane. `cnt_fail` counts frames with a failed lane. Each count already includes the frame shown with `out_vld`, and both counts stop at all ones.
- R9: While `rst` is high, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Frame strobe |
| in_frame | input | 120 | Received frame |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| out_hdr | output | 4 | Corrected header |
| out_sc | output | 4 | Corrected control field |
| out_ttc | output | 16 | Corrected timing/trigger field |
| out_daq | output | 64 | Corrected acquisition field |
| out_fixed | output | 2 | Per-lane repair made |
| out_fail | output | 2 | Per-lane undecodable |
| out_bad | output | 1 | Any lane undecodable |
| cnt_fixed | output | CNT_W | Saturating count of repaired frames |
| cnt_fail | output | CNT_W | Saturating count of failed frames |

## Verification
Clean frames, including all-zero and all-one data, test whether the decoder leaves valid codewords alone. Frames with a single error and with paired errors, at check, data and edge positions, test the one-error and two-error solver paths separately. Frames with four errors and aligned 16-bit bursts at both ends of the frame test whether the two lanes stay independent. Frames with three errors in one lane test the failure path: a lane that claims a repair must be within distance two of a re-encoded codeword, and a lane that fails must come out raw.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int SYM_W   = 4;
  localparam int CW_N    = 15;
  localparam int NPAR    = 4;
  localparam int CW_K    = CW_N - NPAR;
  localparam int LANES   = 2;
  localparam int FRAME_W = LANES * CW_N * SYM_W;
  localparam int DATA_W  = LANES * CW_K * SYM_W;
  localparam int HDR_W   = 4;
  localparam int SC_W    = 4;
  localparam int TTC_W   = 16;
  localparam int DAQ_W   = DATA_W - HDR_W - SC_W - TTC_W;
  // reduction term of x^4 + x + 1
  localparam logic [SYM_W-1:0] FIELD_LOW = 4'h3;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [CW_N-1:0][SYM_W-1:0] cw_t;
  typedef logic [CW_K-1:0][SYM_W-1:0] dat_t;
  typedef logic [NPAR-1:0][SYM_W-1:0] syn_t;

  function automatic sym_t gf_xtime(sym_t a);
    sym_t s;
    s = sym_t'({a[SYM_W-2:0], 1'b0});
    return a[SYM_W-1] ? (s ^ FIELD_LOW) : s;
  endfunction

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t r, x;
    r = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) r = r ^ x;
      x = gf_xtime(x);
    end
    return r;
  endfunction

  // a^(2^m - 2) is the inverse of a; maps zero to zero
  function automatic sym_t gf_inv(sym_t a);
    sym_t r, b;
    int   e;
    r = sym_t'(1);
    b = a;
    e = CW_N - 1;
    for (int i = 0; i < SYM_W; i++) begin
      if (e[i]) r = gf_mul(r, b);
      b = gf_mul(b, b);
    end
    return r;
  endfunction

  function automatic sym_t gf_apow(int n);
    sym_t r;
    r = sym_t'(1);
    for (int i = 0; i < CW_N; i++)
      if (i < (n % CW_N)) r = gf_xtime(r);
    return r;
  endfunction
endpackage

// File: rtl/rsd_syndrome.sv
module rsd_syndrome
  import rsd_pkg::*;
(
  input  cw_t  cw,
  output syn_t syn
);
  for (genvar i = 0; i < NPAR; i++) begin : g_root
    sym_t acc;
    always_comb begin
      acc = '0;
      for (int j = CW_N - 1; j >= 0; j--)
        acc = gf_mul(acc, gf_apow(i + 1)) ^ cw[j];
    end
    assign syn[i] = acc;
  end
endmodule

// File: rtl/rsd_solver.sv
module rsd_solver
  import rsd_pkg::*;
(
  input  syn_t syn,
  output sym_t sig1,
  output sym_t sig2,
  output sym_t om0,
  output sym_t om1,
  output sym_t sig1_inv,
  output logic any_err,
  output logic two_err,
  output logic early_bad
);
  sym_t s1, s2, s3, s4, det, dinv, x1;

  always_comb begin
    s1 = syn[0];
    s2 = syn[1];
    s3 = syn[2];
    s4 = syn[3];
    any_err = |syn;
    det  = gf_mul(s2, s2) ^ gf_mul(s1, s3);
    dinv = gf_inv(det);
    x1   = gf_mul(s2, gf_inv(s1));
    if (det != '0) begin
      sig1      = gf_mul(gf_mul(s2, s3) ^ gf_mul(s1, s4), dinv);
      sig2      = gf_mul(gf_mul(s2, s4) ^ gf_mul(s3, s3), dinv);
      two_err   = 1'b1;
      early_bad = (sig2 == '0);
    end else begin
      sig1      = x1;
      sig2      = '0;
      two_err   = 1'b0;
      early_bad = (s1 == '0) || (s3 != gf_mul(s2, x1)) || (s4 != gf_mul(s3, x1));
    end
    om0      = s1;
    om1      = s2 ^ gf_mul(sig1, s1);
    sig1_inv = gf_inv(sig1);
  end
endmodule

// File: rtl/rsd_corrector.sv
module rsd_corrector
  import rsd_pkg::*;
(
  input  cw_t  raw,
  input  sym_t sig1,
  input  sym_t sig2,
  input  sym_t om0,
  input  sym_t om1,
  input  sym_t sig1_inv,
  input  logic any_err,
  input  logic two_err,
  input  logic early_bad,
  output dat_t data_out,
  output logic ok,
  output logic bad
);
  localparam int RC_W = $clog2(CW_N + 1);

  logic [CW_N-1:0] hit;
  logic [RC_W-1:0] root_cnt, need;

  for (genvar j = 0; j < CW_N; j++) begin : g_pos
    sym_t xi, lam;
    always_comb begin
      xi  = gf_apow((CW_N - j) % CW_N);
      lam = sym_t'(1) ^ gf_mul(sig1, xi) ^ gf_mul(sig2, gf_mul(xi, xi));
    end
    assign hit[j] = (lam == '0);
    if (j >= NPAR) begin : g_data
      sym_t ev;
      always_comb ev = gf_mul(om0 ^ gf_mul(om1, xi), sig1_inv);
      assign data_out[j-NPAR] = raw[j] ^ ((ok && hit[j]) ? ev : '0);
    end
  end

  always_comb begin
    root_cnt = RC_W'($countones(hit));
    need     = two_err ? RC_W'(2) : RC_W'(1);
    ok       = any_err && !early_bad && (root_cnt == need);
    bad      = any_err && !ok;
  end
endmodule

// File: rtl/rsd_frame_decoder.sv
module rsd_frame_decoder
  import rsd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [FRAME_W-1:0] in_frame,
  output logic               out_vld,
  output logic [HDR_W-1:0]   out_hdr,
  output logic [SC_W-1:0]    out_sc,
  output logic [TTC_W-1:0]   out_ttc,
  output logic [DAQ_W-1:0]   out_daq,
  output logic [LANES-1:0]   out_fixed,
  output logic [LANES-1:0]   out_fail,
  output logic               out_bad,
  output logic [CNT_W-1:0]   cnt_fixed,
  output logic [CNT_W-1:0]   cnt_fail
);
  cw_t               lane_raw [LANES];
  dat_t              lane_dat [LANES];
  logic [LANES-1:0]  ok_v, bad_v;
  logic [DATA_W-1:0] corr_data;

  for (genvar w = 0; w < LANES; w++) begin : g_lane
    syn_t syn;
    sym_t sig1, sig2, om0, om1, sig1_inv;
    logic any_err, two_err, early_bad;

    for (genvar j = 0; j < CW_N; j++) begin : g_split
      assign lane_raw[w][j] = in_frame[(LANES*j + w)*SYM_W +: SYM_W];
      if (j >= NPAR) begin : g_merge
        assign corr_data[(LANES*(j-NPAR) + w)*SYM_W +: SYM_W] = lane_dat[w][j-NPAR];
      end
    end

    rsd_syndrome u_syn (.cw(lane_raw[w]), .syn(syn));

    rsd_solver u_sol (
      .syn(syn), .sig1(sig1), .sig2(sig2), .om0(om0), .om1(om1),
      .sig1_inv(sig1_inv), .any_err(any_err), .two_err(two_err),
      .early_bad(early_bad)
    );

    rsd_corrector u_cor (
      .raw(lane_raw[w]), .sig1(sig1), .sig2(sig2), .om0(om0), .om1(om1),
      .sig1_inv(sig1_inv), .any_err(any_err), .two_err(two_err),
      .early_bad(early_bad), .data_out(lane_dat[w]), .ok(ok_v[w]),
      .bad(bad_v[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_hdr   <= '0;
      out_sc    <= '0;
      out_ttc   <= '0;
      out_daq   <= '0;
      out_fixed <= '0;
      out_fail  <= '0;
      out_bad   <= 1'b0;
      cnt_fixed <= '0;
      cnt_fail  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_hdr   <= corr_data[DATA_W-1 -: HDR_W];
        out_sc    <= corr_data[DATA_W-HDR_W-1 -: SC_W];
        out_ttc   <= corr_data[DAQ_W+TTC_W-1 -: TTC_W];
        out_daq   <= corr_data[DAQ_W-1:0];
        out_fixed <= ok_v;
        out_fail  <= bad_v;
        out_bad   <= |bad_v;
        if (|bad_v) begin
          if (cnt_fail != '1) cnt_fail <= cnt_fail + CNT_W'(1);
        end else if (|ok_v) begin
          if (cnt_fixed != '1) cnt_fixed <= cnt_fixed + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rsd_frame_decoder_chk.sv
module rsd_frame_decoder_chk
  import rsd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             out_vld,
  input logic [HDR_W-1:0] out_hdr,
  input logic [DAQ_W-1:0] out_daq,
  input logic [LANES-1:0] out_fixed,
  input logic [LANES-1:0] out_fail,
  input logic             out_bad,
  input logic [CNT_W-1:0] cnt_fixed,
  input logic [CNT_W-1:0] cnt_fail
);
  assert_vld_follow_R7: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  assert_vld_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_daq) && $stable(out_hdr) && $stable(out_fixed) && $stable(out_fail)));

  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (rst)
    (out_fixed & out_fail) == '0);

  assert_bad_or_R6: assert property (@(posedge clk) disable iff (rst)
    out_bad == (|out_fail));

  assert_fix_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_fixed == '1) |=> (cnt_fixed == '1));

  assert_fail_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_fail == '1) |=> (cnt_fail == '1));

  assert_fix_step_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_fixed != '1) |=>
      (cnt_fixed == $past(cnt_fixed) + CNT_W'(out_vld && !out_bad && (|out_fixed))));

  assert_fail_step_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_fail != '1) |=> (cnt_fail == $past(cnt_fail) + CNT_W'(out_vld && out_bad)));
endmodule

bind rsd_frame_decoder rsd_frame_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld),
  .out_hdr(out_hdr), .out_daq(out_daq), .out_fixed(out_fixed),
  .out_fail(out_fail), .out_bad(out_bad), .cnt_fixed(cnt_fixed),
  .cnt_fail(cnt_fail)
);

// File: tb/sim_rsd_frame_decoder.sv
`timescale 1ns/1ps
module sim_rsd_frame_decoder;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [119:0]  in_frame = '0;
  logic          out_vld, out_bad;
  logic [3:0]    out_hdr, out_sc;
  logic [15:0]   out_ttc;
  logic [63:0]   out_daq;
  logic [1:0]    out_fixed, out_fail;
  logic [CW-1:0] cnt_fixed, cnt_fail;

  always #2.5 clk = ~clk;

  rsd_frame_decoder #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_frame(in_frame),
    .out_vld(out_vld), .out_hdr(out_hdr), .out_sc(out_sc), .out_ttc(out_ttc),
    .out_daq(out_daq), .out_fixed(out_fixed), .out_fail(out_fail),
    .out_bad(out_bad), .cnt_fixed(cnt_fixed), .cnt_fail(cnt_fail)
  );

  int n_chk = 0, n_bad = 0, fail_seen = 0;
  bit done = 0;
  logic [3:0] gc [0:4];
  logic [CW-1:0] m_fix = '0, m_fail = '0;
  logic [87:0] last_od = '0;
  bit pend = 0;
  logic [119:0] p_rx;
  logic [87:0] p_data;
  logic [1:0] p_exact, p_efix;
  string p_tag;

  task automatic chk(input bit ok, input string msg, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  function automatic logic [3:0] gm(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] r = '0, x = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) r ^= x;
      x = x[3] ? ({x[2:0], 1'b0} ^ 4'h3) : {x[2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [3:0] apow(input int n);
    logic [3:0] r = 4'h1;
    for (int i = 0; i < n; i++) r = gm(r, 4'h2);
    return r;
  endfunction

  function automatic logic [119:0] enc(input logic [87:0] d);
    logic [119:0] f = '0;
    logic [3:0] r0, r1, r2, r3, fb;
    f[119:32] = d;
    for (int w = 0; w < 2; w++) begin
      r0 = 0; r1 = 0; r2 = 0; r3 = 0;
      for (int p = 14; p >= 4; p--) begin
        fb = f[(2*p+w)*4 +: 4] ^ r3;
        r3 = r2 ^ gm(fb, gc[3]);
        r2 = r1 ^ gm(fb, gc[2]);
        r1 = r0 ^ gm(fb, gc[1]);
        r0 = gm(fb, gc[0]);
      end
      f[(2*3+w)*4 +: 4] = r3;
      f[(2*2+w)*4 +: 4] = r2;
      f[(2*1+w)*4 +: 4] = r1;
      f[(2*0+w)*4 +: 4] = r0;
    end
    return f;
  endfunction

  function automatic int ldist(input logic [119:0] a, input logic [119:0] b, input int w);
    int n = 0;
    for (int k = w; k < 30; k += 2) if (a[k*4 +: 4] != b[k*4 +: 4]) n++;
    return n;
  endfunction

  function automatic logic [87:0] lmask(input int w);
    logic [87:0] m = '0;
    for (int i = 0; i < 22; i++) if (i % 2 == w) m[i*4 +: 4] = 4'hF;
    return m;
  endfunction

  function automatic logic [119:0] flip(input logic [119:0] f, input int k, input logic [3:0] v);
    f[k*4 +: 4] ^= v;
    return f;
  endfunction

  function automatic logic [3:0] nz4();
    return 4'($urandom % 15 + 1);
  endfunction

  function automatic logic [87:0] rnd88();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic check_pending();
    logic [87:0] od;
    int dd;
    od = {out_hdr, out_sc, out_ttc, out_daq};
    chk(out_vld === 1'b1, "R7 out_vld one cycle after strobe", out_vld, 1);
    for (int w = 0; w < 2; w++) begin
      if (p_exact[w]) begin
        chk(out_fixed[w] == p_efix[w], {p_tag, " R4 fixed flag"}, out_fixed, p_efix);
        chk(out_fail[w] == 1'b0, {p_tag, " R6 no fail flag"}, out_fail, 0);
        chk(((od ^ p_data) & lmask(w)) == 0, {p_tag, " R1/R5 lane data"}, od, p_data);
      end else begin
        chk(out_fixed[w] ^ out_fail[w], "R6 exactly one flag on three-error lane", {out_fixed, out_fail}, 0);
        if (out_fail[w]) begin
          fail_seen++;
          chk(((od ^ p_rx[119:32]) & lmask(w)) == 0, "R6 failed lane left raw", od, p_rx[119:32]);
        end else begin
          dd = ldist(p_rx, enc(od), w);
          chk(dd >= 1 && dd <= 2, "R4 repair within distance two", dd, 2);
        end
      end
    end
    if (p_exact == 2'b11) begin
      chk(out_hdr == p_data[87:84] && out_sc == p_data[83:80] && out_ttc == p_data[79:64]
          && out_daq == p_data[63:0], "R2 field split", od, p_data);
    end
    chk(out_bad == |out_fail, "R6 out_bad", out_bad, |out_fail);
    if (|out_fail) begin
      if (m_fail != '1) m_fail++;
    end else if (|out_fixed) begin
      if (m_fix != '1) m_fix++;
    end
    chk(cnt_fixed == m_fix, "R8 repaired count", cnt_fixed, m_fix);
    chk(cnt_fail == m_fail, "R8 failed count", cnt_fail, m_fail);
    last_od = od;
  endtask

  task automatic push(input logic [119:0] rx, input logic [87:0] d, input logic [1:0] ex,
                      input logic [1:0] ef, input string tag);
    @(negedge clk);
    if (pend) check_pending();
    in_vld = 1'b1;
    in_frame = rx;
    pend = 1; p_rx = rx; p_data = d; p_exact = ex; p_efix = ef; p_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    if (pend) check_pending();
    else begin
      chk(out_vld == 1'b0, "R7 no valid without strobe", out_vld, 0);
      chk({out_hdr, out_sc, out_ttc, out_daq} == last_od, "R7 outputs held, input ignored",
          {out_hdr, out_sc, out_ttc, out_daq}, last_od);
    end
    pend = 0;
    in_vld = 1'b0;
    in_frame = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [87:0] d;
    logic [119:0] f;
    logic [15:0] b;
    int w, p1, p2, p3, s, sel;
    logic [1:0] ef;
    void'($urandom(32'h5eed));
    gc[0] = 4'h1; gc[1] = 0; gc[2] = 0; gc[3] = 0; gc[4] = 0;
    for (int i = 1; i <= 4; i++)
      for (int k = 4; k >= 0; k--)
        gc[k] = (k > 0 ? gc[k-1] : 4'h0) ^ gm(gc[k], apow(i));

    repeat (3) @(negedge clk);
    chk({out_vld, out_hdr, out_sc, out_ttc, out_daq, out_fixed, out_fail, out_bad, cnt_fixed, cnt_fail} == 0,
        "R9 reset state", {out_vld, out_daq, out_fixed, out_fail, out_bad}, 0);
    rst = 1'b0;
    idle();

    // directed corner cases
    push(enc('0), '0, 2'b11, 2'b00, "R3 clean zero"); idle();
    d = '1;
    push(enc(d), d, 2'b11, 2'b00, "R3 clean ones"); idle();
    d = rnd88();
    push(flip(enc(d), 0, 4'h9), d, 2'b11, 2'b01, "R4 check symbol 0"); idle();
    push(flip(enc(d), 29, 4'hF), d, 2'b11, 2'b10, "R4 top symbol"); idle();
    push(flip(flip(enc(d), 1, 4'h1), 29, 4'h8), d, 2'b11, 2'b10, "R4 double edges"); idle();
    push(enc(d) ^ {16'hFFFF, 104'h0}, d, 2'b11, 2'b11, "R5 burst top"); idle();
    push(enc(d) ^ 120'hA5C3, d, 2'b11, 2'b11, "R5 burst bottom");
    d = rnd88();
    push(flip(enc(d), 13, 4'h2), d, 2'b11, 2'b10, "R7 back-to-back");
    idle(); idle(); idle();

    for (int it = 0; it < 320; it++) begin
      d = rnd88();
      f = enc(d);
      sel = $urandom % 6;
      w = $urandom % 2;
      p1 = $urandom % 15;
      p2 = (p1 + 1 + $urandom % 14) % 15;
      case (sel)
        0: push(f, d, 2'b11, 2'b00, "R3 clean");
        1: push(flip(f, 2*p1+w, nz4()), d, 2'b11, 2'(1 << w), "R4 single");
        2: push(flip(flip(f, 2*p1+w, nz4()), 2*p2+w, nz4()), d, 2'b11, 2'(1 << w), "R4 double");
        3: begin
          f = flip(flip(f, 2*p1, nz4()), 2*p2, nz4());
          p1 = $urandom % 15;
          p2 = (p1 + 1 + $urandom % 14) % 15;
          f = flip(flip(f, 2*p1+1, nz4()), 2*p2+1, nz4());
          push(f, d, 2'b11, 2'b11, "R5 four symbols");
        end
        4: begin
          s = $urandom % 27;
          b = 16'($urandom % 65535 + 1);
          ef = 2'b00;
          for (int q = 0; q < 4; q++) if (b[q*4 +: 4] != 0) ef[(s+q) % 2] = 1'b1;
          f[s*4 +: 16] ^= b;
          push(f, d, 2'b11, ef, "R5 aligned burst");
        end
        default: begin
          p3 = $urandom % 15;
          while (p3 == p1 || p3 == p2) p3 = (p3 + 1) % 15;
          f = flip(flip(flip(f, 2*p1+w, nz4()), 2*p2+w, nz4()), 2*p3+w, nz4());
          push(f, d, (w == 0) ? 2'b10 : 2'b01, 2'b00, "R6 three errors");
        end
      endcase
      if ($urandom % 3 != 0) idle();
    end
    idle(); idle();
    chk(fail_seen > 0, "R6 undecodable lane reached", fail_seen, 1);
    chk(cnt_fixed == '1, "R8 repaired count saturated", cnt_fixed, '1);
    finish_run();
  end
endmodule